// File: doc/BRIEF.md
# Smoothly Trimmed One-Second Prescaler

This block divides a 32.768 kHz low-speed clock down to the single-cycle tick that advances a calendar once per second. The division happens in two stages. A small first stage produces an intermediate clock enable. A wider second stage counts those enables and emits the tick. Each stage has its own programmable divisor. Both divisors are written as the divide value minus one, and the block takes a new pair only when a tick completes, so a tick period is never made from a mix of old and new values.

A trim unit sits in front of the divider chain. It corrects the error of the crystal frequency over a repeating window of 2^20 input cycles, which is 32 seconds. Inside each window the trim unit can delete up to 511 input pulses. It can also add 512 extra counts, one every 2048 input cycles. The net correction therefore runs from -511 to +512 pulses per window, in steps of about 0.954 ppm, for a total span of roughly ±487 ppm. The deleted pulses are chosen by comparing the bit-reversed window position with the mask count, which spreads them evenly across the window. The trim settings are captured only at the end of a window. A one-cycle flag marks that point.

When the mask count is zero and the add control is off, the tick period is exactly the product of the two divide values.

Top module: `rtc_smooth_prescaler`

## Requirements
- R1: While reset is held, sec_tick, async_en and trim_win_end are 0, and the divisor and trim inputs are taken directly as the active settings.
- R2: With no trim active, async_en pulses for one cycle every (async_div_m1+1) input cycles. A programmed value of 0 behaves as 1, giving a divide by 2.
- R3: With no trim active, sec_tick pulses for one cycle every (async_div_m1+1)*(sync_div_m1+1) input cycles, and every sec_tick coincides with an async_en pulse.
- R4: A change of async_div_m1 or sync_div_m1 leaves the tick interval that is running unchanged. The new values apply from the interval that starts at the next sec_tick.
- R5: trim_win_end is high for exactly one cycle every 2^WIN_LOG2 input cycles.
- R6: A mask count m removes exactly m input pulses from each window, with 0 <= m <= 2^MASK_W-1.
- R7: When trim_add is 1, 2^MASK_W extra input counts are added to each window, one every 2^(WIN_LOG2-MASK_W) cycles, at window positions whose low WIN_LOG2-MASK_W bits are zero.
- R8: trim_mask and trim_add are captured only at a window end. A change made during a window has no effect until the next window starts.
- R9: Masked pulses fall only on window positions whose low WIN_LOG2-MASK_W bits are zero. A position is masked when its bit-reversed value is below the mask count, so a mask of 2^(MASK_W-1) places half of its pulses in each half of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lsc | input | 1 | Low-speed input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| async_div_m1 | input | ASYNC_W | First-stage divide value minus one |
| sync_div_m1 | input | SYNC_W | Second-stage divide value minus one |
| trim_mask | input | MASK_W | Number of input pulses to remove per window |
| trim_add | input | 1 | Add 2^MASK_W counts per window |
| sec_tick | output | 1 | One-cycle calendar tick |
| async_en | output | 1 | One-cycle first-stage clock enable |
| trim_win_end | output | 1 | One-cycle marker at the end of each trim window |

## Verification
A corrupted stage counter or a divisor loaded at the wrong time shows up as a wrong interval between two sec_tick pulses or two async_en pulses. It is visible within one tick period. A fault in the window position or in the capture of the trim settings changes the number of async_en pulses counted between two trim_win_end pulses, so it appears within one window. Uneven placement of the masked pulses shows up as a mismatch between the counts from the two half-windows.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
    // Number of prescaler input counts contributed by one clock cycle.
    typedef logic [1:0] pulse_wt_t;
    localparam pulse_wt_t WT_NONE   = 2'd0;
    localparam pulse_wt_t WT_SINGLE = 2'd1;
    localparam pulse_wt_t WT_DOUBLE = 2'd2;
endpackage

// File: rtl/rtc_trim_window.sv
module rtc_trim_window
    import rtc_presc_pkg::*;
#(
    parameter int WIN_LOG2 = 20,
    parameter int MASK_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] mask_in,
    input  logic              add_in,
    output pulse_wt_t         weight,
    output logic              win_end_q
);
    localparam int SLOT_W = WIN_LOG2 - MASK_W;

    typedef struct packed {
        logic [WIN_LOG2-1:0] pos;
        logic [MASK_W-1:0]   mask_act;
        logic                add_act;
        logic                win_end;
    } win_state_t;

    win_state_t q, d;
    logic [WIN_LOG2-1:0] pos_rev;
    logic slot_hit, mask_hit, add_hit;

    // Bit-reverse the window position so that masked cycles are spread out.
    for (genvar i = 0; i < WIN_LOG2; i++) begin : g_rev
        assign pos_rev[i] = q.pos[WIN_LOG2-1-i];
    end

    always_comb begin
        d          = q;
        d.pos      = q.pos + 1'b1;
        d.win_end  = (q.pos == '1);
        if (q.pos == '1) begin
            d.mask_act = mask_in;
            d.add_act  = add_in;
        end
        slot_hit = (q.pos[SLOT_W-1:0] == '0);
        mask_hit = (pos_rev < WIN_LOG2'(q.mask_act));
        add_hit  = q.add_act && slot_hit;
        if (mask_hit && !add_hit)      weight = WT_NONE;
        else if (add_hit && !mask_hit) weight = WT_DOUBLE;
        else                           weight = WT_SINGLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{pos: '0, mask_act: mask_in, add_act: add_in, win_end: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign win_end_q = q.win_end;

    a_r9_trim_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (weight != WT_SINGLE) |-> (q.pos[SLOT_W-1:0] == '0));
    a_r8_trim_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !win_end_q) |-> ($stable(q.mask_act) && $stable(q.add_act)));
    a_r5_win_single: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_q |=> !win_end_q);
    a_r5_win_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_q |-> (q.pos == '0));
endmodule

// File: rtl/rtc_async_stage.sv
module rtc_async_stage
    import rtc_presc_pkg::*;
#(
    parameter int ASYNC_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pulse_wt_t          weight,
    input  logic [ASYNC_W-1:0] div_m1,
    output logic               ce_d,
    output logic               ce_q
);
    typedef struct packed {
        logic [ASYNC_W-1:0] cnt;
        logic               ce;
    } async_state_t;

    async_state_t q, d;
    logic [ASYNC_W-1:0] div_eff;
    logic [ASYNC_W:0]   sum;

    always_comb begin
        d       = q;
        // A programmed 0 is raised to 1 so that a double count never wraps twice.
        div_eff = (div_m1 == '0) ? ASYNC_W'(1) : div_m1;
        sum     = {1'b0, q.cnt} + (ASYNC_W+1)'(weight);
        if (sum > {1'b0, div_eff}) begin
            d.cnt = ASYNC_W'(sum - {1'b0, div_eff} - 1'b1);
            d.ce  = 1'b1;
        end else begin
            d.cnt = sum[ASYNC_W-1:0];
            d.ce  = 1'b0;
        end
        ce_d = d.ce;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ce_q = q.ce;

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= div_eff);
endmodule

// File: rtl/rtc_sync_stage.sv
module rtc_sync_stage #(
    parameter int ASYNC_W = 7,
    parameter int SYNC_W  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_d,
    input  logic [ASYNC_W-1:0] adiv_in,
    input  logic [SYNC_W-1:0]  sdiv_in,
    output logic [ASYNC_W-1:0] adiv_act,
    output logic               tick_q
);
    typedef struct packed {
        logic [SYNC_W-1:0]  scnt;
        logic [ASYNC_W-1:0] adiv;
        logic [SYNC_W-1:0]  sdiv;
        logic               tick;
    } sync_state_t;

    sync_state_t q, d;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (ce_d) begin
            if (q.scnt == q.sdiv) begin
                d.scnt = '0;
                d.tick = 1'b1;
                d.adiv = adiv_in;
                d.sdiv = sdiv_in;
            end else begin
                d.scnt = q.scnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{scnt: '0, adiv: adiv_in, sdiv: sdiv_in, tick: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign adiv_act = q.adiv;
    assign tick_q   = q.tick;

    a_r4_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !tick_q) |-> ($stable(q.adiv) && $stable(q.sdiv)));
    a_r3_scnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.scnt <= q.sdiv);
endmodule

// File: rtl/rtc_smooth_prescaler.sv
module rtc_smooth_prescaler
    import rtc_presc_pkg::*;
#(
    parameter int WIN_LOG2 = 20,
    parameter int MASK_W   = 9,
    parameter int ASYNC_W  = 7,
    parameter int SYNC_W   = 15
) (
    input  logic               clk_lsc,
    input  logic               rst_n,
    input  logic [ASYNC_W-1:0] async_div_m1,
    input  logic [SYNC_W-1:0]  sync_div_m1,
    input  logic [MASK_W-1:0]  trim_mask,
    input  logic               trim_add,
    output logic               sec_tick,
    output logic               async_en,
    output logic               trim_win_end
);
    pulse_wt_t          weight;
    logic               ce_d;
    logic [ASYNC_W-1:0] adiv_act;

    rtc_trim_window #(.WIN_LOG2(WIN_LOG2), .MASK_W(MASK_W)) trim_i (
        .clk       (clk_lsc),
        .rst_n     (rst_n),
        .mask_in   (trim_mask),
        .add_in    (trim_add),
        .weight    (weight),
        .win_end_q (trim_win_end)
    );

    rtc_async_stage #(.ASYNC_W(ASYNC_W)) async_i (
        .clk    (clk_lsc),
        .rst_n  (rst_n),
        .weight (weight),
        .div_m1 (adiv_act),
        .ce_d   (ce_d),
        .ce_q   (async_en)
    );

    rtc_sync_stage #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) sync_i (
        .clk      (clk_lsc),
        .rst_n    (rst_n),
        .ce_d     (ce_d),
        .adiv_in  (async_div_m1),
        .sdiv_in  (sync_div_m1),
        .adiv_act (adiv_act),
        .tick_q   (sec_tick)
    );

    a_r3_tick_with_ce: assert property (@(posedge clk_lsc) disable iff (!rst_n)
        sec_tick |-> async_en);
endmodule

// File: tb/rtc_smooth_prescaler_tb.sv
module rtc_smooth_prescaler_tb_top;
    localparam int WIN_LOG2 = 8;
    localparam int MASK_W   = 4;
    localparam int ASYNC_W  = 3;
    localparam int SYNC_W   = 4;
    localparam int WIN      = 1 << WIN_LOG2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ASYNC_W-1:0] adiv = 3'd1;
    logic [SYNC_W-1:0]  sdiv = 4'd0;
    logic [MASK_W-1:0]  mask = '0;
    logic               add = 1'b0;
    logic sec_tick, async_en, win_end;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_smooth_prescaler #(.WIN_LOG2(WIN_LOG2), .MASK_W(MASK_W),
                           .ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) dut_i (
        .clk_lsc(clk), .rst_n(rst_n), .async_div_m1(adiv), .sync_div_m1(sdiv),
        .trim_mask(mask), .trim_add(add), .sec_tick(sec_tick),
        .async_en(async_en), .trim_win_end(win_end)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int t);
        do @(negedge clk); while (!sec_tick);
        t = cyc;
    endtask

    task automatic wait_ce(output int t);
        do @(negedge clk); while (!async_en);
        t = cyc;
    endtask

    task automatic wait_win(output int t);
        do @(negedge clk); while (!win_end);
        t = cyc;
    endtask

    // Counts async_en pulses over the next n cycles.
    task automatic count_ce(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (async_en) c++;
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t0, t1, t2, c;
        repeat (4) @(negedge clk);
        // R1: outputs stay low during reset
        check(!sec_tick && !async_en && !win_end, "R1 reset outputs",
              {sec_tick, async_en, win_end}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: divisor sweep with trim off
        for (int a = 0; a < 8; a++) begin
            for (int si = 0; si < 3; si++) begin
                int s, ea;
                s = (si == 0) ? 0 : ((si == 1) ? 3 : 15);
                ea = (a == 0) ? 2 : a + 1;
                wait_tick(t0);
                adiv = 3'(a);
                sdiv = 4'(s);
                wait_tick(t1);
                wait_tick(t2);
                check(t2 - t1 == ea * (s + 1), "R3 tick period", t2 - t1, ea * (s + 1));
                wait_ce(t1);
                wait_ce(t2);
                check(t2 - t1 == ea, "R2 async_en period", t2 - t1, ea);
            end
        end

        // R4: divisor change applies only from the next tick
        adiv = 3'd3; sdiv = 4'd3;
        wait_tick(t0);
        wait_tick(t0);
        adiv = 3'd5; sdiv = 4'd2;
        wait_tick(t1);
        check(t1 - t0 == 16, "R4 old divisors hold", t1 - t0, 16);
        wait_tick(t2);
        check(t2 - t1 == 18, "R4 new divisors apply", t2 - t1, 18);

        // R5: window end spacing and width
        wait_win(t0);
        @(negedge clk);
        check(!win_end, "R5 window end width", win_end, 0);
        wait_win(t1);
        check(t1 - t0 == WIN, "R5 window period", t1 - t0, WIN);

        // R6/R7: trim sweep, first stage divides by 2
        adiv = 3'd1; sdiv = 4'd15;
        for (int ad = 0; ad < 2; ad++) begin
            for (int m = 0; m < 16; m++) begin
                int exp;
                mask = 4'(m);
                add = ad[0];
                wait_win(t0);
                count_ce(WIN, c);
                exp = (WIN - m + 16 * ad) / 2;
                check(absd(c, exp) <= 1, ad ? "R7 added pulses per window" : "R6 masked pulses per window", c, exp);
            end
        end

        // R8: a change during a window waits for the window end
        mask = '0; add = 1'b0;
        wait_win(t0);
        wait_win(t0);
        mask = 4'd15; add = 1'b0;
        count_ce(WIN, c);
        check(absd(c, WIN / 2) <= 1, "R8 no effect mid-window", c, WIN / 2);
        count_ce(WIN, c);
        check(absd(c, (WIN - 15) / 2) <= 1, "R8 applied next window", c, (WIN - 15) / 2);

        // R9/R7: even spread across half-windows
        mask = 4'd8; add = 1'b0;
        wait_win(t0);
        wait_win(t0);
        count_ce(WIN / 2, c);
        check(absd(c, (WIN / 2 - 4) / 2) <= 1, "R9 first half masked", c, (WIN / 2 - 4) / 2);
        count_ce(WIN / 2, c);
        check(absd(c, (WIN / 2 - 4) / 2) <= 1, "R9 second half masked", c, (WIN / 2 - 4) / 2);
        mask = '0; add = 1'b1;
        wait_win(t0);
        wait_win(t0);
        count_ce(WIN / 2, c);
        check(absd(c, (WIN / 2 + 8) / 2) <= 1, "R7 first half added", c, (WIN / 2 + 8) / 2);
        count_ce(WIN / 2, c);
        check(absd(c, (WIN / 2 + 8) / 2) <= 1, "R7 second half added", c, (WIN / 2 + 8) / 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule